// File: doc/BRIEF.md
# Lane-Parallel Carry-Less Multiplier

This unit forms GF(2) polynomial products of 64-bit words. Each source vector is 512 bits wide and is cut into 128-bit lanes. In every lane, two bits of an 8-bit control byte choose which 64-bit half of each source feeds that lane's multiplier. The 127-bit product fills the lane's 128-bit result slot, and the top bit of the slot is always zero.

Two policies govern the destination bits above the lanes being computed. In legacy mode only lane 0 is computed, and every bit above bit 127 is copied from the previous destination value supplied on `dst_old`. In vector mode a 2-bit length code sets how many lanes are computed (1, 2 or 4), and every bit above that length reads as zero. The result is registered one clock after a valid input and is held until the next valid input.

Top module: `lane_clmul_unit`

## Requirements
- R1: Control bit 0 selects the half of each `src_a` lane: value 0 takes lane bits [63:0] and value 1 takes lane bits [127:64]. The encodings 0x00, 0x01, 0x10 and 0x11 give low×low, high×low, low×high and high×high, with the `src_a` half named first.
- R2: Control bit 4 selects the half of each `src_b` lane, using the same rule as R1.
- R3: Control bits 1, 2, 3, 5, 6 and 7 have no effect on `result`.
- R4: Bit k of a computed lane, for k from 0 to 126, is the XOR of (x[i] AND y[j]) over all i+j=k, where x and y are the selected 64-bit halves. Bit 127 of every computed lane is 0.
- R5: In vector mode (`mode`=1), the length code 0, 1 or 2 selects 1, 2 or 4 computed lanes (128, 256 or 512 bits), and code 3 behaves as code 2. All computed lanes use the same half selection.
- R6: In vector mode, `result` bits from the active vector length up to bit 511 are 0.
- R7: In legacy mode (`mode`=0), only lane 0 is computed, `result[511:128]` equals `dst_old[511:128]` as presented with the valid input, and `vlen` has no effect.
- R8: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1. `result` takes its new value in that same cycle.
- R9: While `in_valid` is 0, `result` keeps its last value.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value, used in legacy mode |
| imm | input | 8 | Half-select control byte (bits 0 and 4 used) |
| vlen | input | 2 | Vector length code: 0=128, 1=256, 2 or 3=512 |
| mode | input | 1 | 0 = legacy upper-bit keep, 1 = vector upper-bit zero |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 512 | Registered product vector |

## Verification
The unit holds state only in the result register and its valid flag. A wrong selection, a wrong lane mask or a corrupted product therefore shows up at the ports on the very next edge after the operation is accepted. A register that fails to hold its value shows up at the first idle cycle after an operation. Known-answer vectors cover the four half encodings and settings of the ignored control bits. Random operands, compared against an independent bit-pair model, cover every length code in both modes, so a lane mask or a keep path that is off by one lane corrupts a visible 128-bit slot.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

   localparam int CTL_W     = 8;
   localparam int SEL_A_BIT = 0;
   localparam int SEL_B_BIT = 4;

   typedef enum logic [1:0] {
      VL_128 = 2'd0,
      VL_256 = 2'd1,
      VL_512 = 2'd2,
      VL_ALT = 2'd3
   } vlen_e;

   // number of lanes requested by a length code, capped at the lanes built
   function automatic int lanes_for(input logic [1:0] code, input int built);
      int req;
      case (vlen_e'(code))
         VL_128:  req = 1;
         VL_256:  req = 2;
         default: req = 4;
      endcase
      return (req > built) ? built : req;
   endfunction

endpackage

// File: rtl/clmul_word_mul.sv
module clmul_word_mul #(
   parameter int W = 64
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int PW = 2 * W;

   always_comb begin
      logic [PW-1:0] acc;
      acc = '0;
      for (int i = 0; i < W; i++) begin
         if (x[i]) acc = acc ^ ({{W{1'b0}}, y} << i);
      end
      p = acc;
   end

endmodule

// File: rtl/clmul_lane.sv
module clmul_lane #(
   parameter int LANE_W = 128
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   input  logic              pick_a_hi,
   input  logic              pick_b_hi,
   output logic [LANE_W-1:0] prod
);
   localparam int HW = LANE_W / 2;

   logic [HW-1:0] op_x;
   logic [HW-1:0] op_y;

   assign op_x = pick_a_hi ? a_lane[LANE_W-1:HW] : a_lane[HW-1:0];
   assign op_y = pick_b_hi ? b_lane[LANE_W-1:HW] : b_lane[HW-1:0];

   clmul_word_mul #(.W(HW)) u_mul (
      .x (op_x),
      .y (op_y),
      .p (prod)
   );

endmodule

// File: rtl/clmul_lane_ctl.sv
module clmul_lane_ctl #(
   parameter int N_LANES = 4
) (
   input  logic               mode,
   input  logic [1:0]         vlen,
   output logic [N_LANES-1:0] lane_on,
   output logic [N_LANES-1:0] lane_keep
);
   import clmul_pkg::*;

   always_comb begin
      int act;
      act = lanes_for(vlen, N_LANES);
      for (int l = 0; l < N_LANES; l++) begin
         lane_on[l]   = mode ? (l < act) : (l == 0);
         lane_keep[l] = !mode && (l != 0);
      end
   end

endmodule

// File: rtl/lane_clmul_unit.sv
module lane_clmul_unit #(
   parameter int LANE_W  = 128,
   parameter int N_LANES = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   input  logic [LANE_W*N_LANES-1:0]   src_a,
   input  logic [LANE_W*N_LANES-1:0]   src_b,
   input  logic [LANE_W*N_LANES-1:0]   dst_old,
   input  logic [7:0]                  imm,
   input  logic [1:0]                  vlen,
   input  logic                        mode,
   output logic                        out_valid,
   output logic [LANE_W*N_LANES-1:0]   result
);
   import clmul_pkg::*;

   localparam int VW = LANE_W * N_LANES;

   if (LANE_W % 2 != 0) begin : g_bad_lane
      $error("LANE_W must be even");
   end
   if (N_LANES != 2 && N_LANES != 4) begin : g_bad_count
      $error("N_LANES must be 2 or 4");
   end

   logic              sel_a_hi;
   logic              sel_b_hi;
   logic              imm_unused;
   logic [N_LANES-1:0] lane_on;
   logic [N_LANES-1:0] lane_keep;
   logic [VW-1:0]     nxt;
   logic [VW-1:0]     res_q;
   logic              vld_q;

   assign sel_a_hi   = imm[SEL_A_BIT];
   assign sel_b_hi   = imm[SEL_B_BIT];
   assign imm_unused = ^{imm[7:5], imm[3:1]};

   clmul_lane_ctl #(.N_LANES(N_LANES)) u_ctl (
      .mode      (mode),
      .vlen      (vlen),
      .lane_on   (lane_on),
      .lane_keep (lane_keep)
   );

   for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      logic [LANE_W-1:0] prod;

      clmul_lane #(.LANE_W(LANE_W)) u_lane (
         .a_lane    (src_a[l*LANE_W +: LANE_W]),
         .b_lane    (src_b[l*LANE_W +: LANE_W]),
         .pick_a_hi (sel_a_hi),
         .pick_b_hi (sel_b_hi),
         .prod      (prod)
      );

      always_comb begin
         if (lane_on[l])        nxt[l*LANE_W +: LANE_W] = prod;
         else if (lane_keep[l]) nxt[l*LANE_W +: LANE_W] = dst_old[l*LANE_W +: LANE_W];
         else                   nxt[l*LANE_W +: LANE_W] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) res_q <= nxt;
      end
   end

   assign out_valid = vld_q;
   assign result    = res_q;

endmodule

// File: rtl/lane_clmul_chk.sv
module lane_clmul_chk #(
   parameter int LANE_W  = 128,
   parameter int N_LANES = 4
) (
   input logic                               clk,
   input logic                               rst,
   input logic                               in_valid,
   input logic                               mode,
   input logic [1:0]                         vlen,
   input logic [LANE_W*N_LANES-1:LANE_W]     dst_hi,
   input logic                               out_valid,
   input logic [LANE_W*N_LANES-1:0]          result
);
   localparam int VW = LANE_W * N_LANES;

   logic [VW-1:0] zmask;
   logic [VW-1:0] zmask_q;

   // slots that must read zero for the presented length code
   always_comb begin
      int act;
      case (vlen)
         2'd0:    act = 1;
         2'd1:    act = 2;
         default: act = 4;
      endcase
      if (act > N_LANES) act = N_LANES;
      for (int l = 0; l < N_LANES; l++)
         zmask[l*LANE_W +: LANE_W] = (l >= act) ? '1 : '0;
   end

   always_ff @(posedge clk) zmask_q <= zmask;

   a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));
   a_r7_keep_upper: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !mode) |=> (result[VW-1:LANE_W] == $past(dst_hi)));
   a_r6_zero_upper: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode) |=> ((result & zmask_q) == '0));
   a_r4_top_bit: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result[LANE_W-1] == 1'b0));
   a_r10_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));

endmodule

bind lane_clmul_unit lane_clmul_chk #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .mode      (mode),
   .vlen      (vlen),
   .dst_hi    (dst_old[LANE_W*N_LANES-1:LANE_W]),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/tb_lane_clmul_unit.sv
`timescale 1ns/1ps
module tb_lane_clmul_unit;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [511:0] src_a = '0;
   logic [511:0] src_b = '0;
   logic [511:0] dst_old = '0;
   logic [7:0]   imm = '0;
   logic [1:0]   vlen = '0;
   logic         mode = 1'b0;
   logic         out_valid;
   logic [511:0] result;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   lane_clmul_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .dst_old(dst_old), .imm(imm), .vlen(vlen), .mode(mode),
      .out_valid(out_valid), .result(result)
   );

   typedef struct packed {
      logic [63:0]  a_lo;
      logic [63:0]  a_hi;
      logic [63:0]  b_lo;
      logic [63:0]  b_hi;
      logic [7:0]   ctl;
      logic [127:0] exp;
   } kat_t;

   // known answers, run in vector mode with 128-bit length
   localparam kat_t KAT [7] = '{
      '{64'd3, 64'd7, 64'd3, 64'd5, 8'h00, 128'h5},                      // R1 low x low
      '{64'd3, 64'd7, 64'd3, 64'd5, 8'h01, 128'h9},                      // R1 high x low
      '{64'd3, 64'd7, 64'd3, 64'd5, 8'h10, 128'hF},                      // R2 low x high
      '{64'd3, 64'd7, 64'd3, 64'd5, 8'h11, 128'h1B},                     // R1 R2 high x high
      '{64'h87, 64'hFFFF, 64'd2, 64'hABCD, 8'hEE, 128'h10E},             // R3 ignored bits set
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'h00,
        128'h5555_5555_5555_5555_5555_5555_5555_5555},                   // R4 dense
      '{64'd1, 64'h8000_0000_0000_0000, 64'd1, 64'h8000_0000_0000_0000, 8'hFF,
        128'h4000_0000_0000_0000_0000_0000_0000_0000}                    // R3 R4 top term
   };

   function automatic logic [127:0] gf_mul(input logic [63:0] x, input logic [63:0] y);
      logic [127:0] r;
      r = '0;
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 64; j++)
            r[i+j] = r[i+j] ^ (x[i] & y[j]);
      return r;
   endfunction

   function automatic logic [511:0] ref_out(input logic [511:0] a, input logic [511:0] b,
                                            input logic [511:0] d, input logic [7:0] c,
                                            input logic [1:0] vl, input logic md);
      logic [511:0] r;
      int n;
      r = md ? 512'd0 : d;
      n = !md ? 1 : (vl == 2'd0) ? 1 : (vl == 2'd1) ? 2 : 4;
      for (int l = 0; l < n; l++) begin
         logic [63:0] x;
         logic [63:0] y;
         x = c[0] ? a[l*128+64 +: 64] : a[l*128 +: 64];
         y = c[4] ? b[l*128+64 +: 64] : b[l*128 +: 64];
         r[l*128 +: 128] = gf_mul(x, y);
      end
      return r;
   endfunction

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [511:0] act,
                        input logic [511:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [511:0] a, input logic [511:0] b, input logic [511:0] d,
                        input logic [7:0] c, input logic [1:0] vl, input logic md);
      @(negedge clk);
      src_a = a; src_b = b; dst_old = d; imm = c; vlen = vl; mode = md;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [511:0] a, b, d, e, held;

      // R10 reset state
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R10 valid", {511'd0, out_valid}, 512'd0);
      check(result == '0, "R10 result", result, 512'd0);
      rst = 1'b0;

      // known-answer table
      for (int t = 0; t < 7; t++) begin
         a = rnd512(); b = rnd512();
         a[127:0] = {KAT[t].a_hi, KAT[t].a_lo};
         b[127:0] = {KAT[t].b_hi, KAT[t].b_lo};
         e = {384'd0, KAT[t].exp};
         issue(a, b, '1, KAT[t].ctl, 2'd0, 1'b1);
         check(out_valid == 1'b1, "R8 kat valid", {511'd0, out_valid}, 512'd1);
         check(result == e, "R1 R2 R3 R4 R6 kat", result, e);
      end

      // random operands across selections, lengths and modes
      for (int md = 0; md < 2; md++)
         for (int vl = 0; vl < 4; vl++)
            for (int s = 0; s < 4; s++) begin
               logic [7:0] c;
               c = 8'($urandom);
               c[0] = s[0];
               c[4] = s[1];
               a = rnd512(); b = rnd512(); d = rnd512();
               e = ref_out(a, b, d, c, 2'(vl), md[0]);
               issue(a, b, d, c, 2'(vl), md[0]);
               check(out_valid == 1'b1, "R8 valid", {511'd0, out_valid}, 512'd1);
               if (md == 1) check(result == e, "R5 R6 vector", result, e);
               else         check(result == e, "R7 legacy", result, e);
            end

      // R9 hold while idle
      held = result;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 idle valid", {511'd0, out_valid}, 512'd0);
      check(result == held, "R9 hold", result, held);

      // R7 legacy ignores vlen
      a = rnd512(); b = rnd512(); d = rnd512();
      e = ref_out(a, b, d, 8'h11, 2'd2, 1'b0);
      issue(a, b, d, 8'h11, 2'd2, 1'b0);
      check(result == e, "R7 vlen ignored", result, e);

      // R10 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(out_valid == 1'b0, "R10 mid valid", {511'd0, out_valid}, 512'd0);
      check(result == '0, "R10 mid result", result, 512'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule